// File: doc/BRIEF.md
# Pseudo-Associative Direct-Mapped Cache

This block is a direct-mapped cache whose lines are grouped in pairs. A request first looks in its home line, selected by the index field of the address, just as a plain direct-mapped cache does. If that line does not hold the block, the partner line is checked in the next cycle. The partner line has the same index except that the top index bit is flipped. A match in the partner line is a slower pseudo-hit. After a pseudo-hit the two lines of the pair trade places, so that a block which keeps being found in its partner line moves to its home line.

A true read miss fetches the block from a lower-level port and places it in the home line. The block that was in the home line moves to the partner line, and whatever the partner line held is dropped. Writes go through to the lower level every time. They update the line that matches and never allocate a line. Each response reports its outcome (fast hit, pseudo-hit or miss) and the number of cycles the access took.

Requests enter over a valid/ready handshake. `req_ready` is high only while the block is idle, so a request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the requester must hold its inputs until then. The lower-level request applies back-pressure through `mem_req_ready`, and the block holds its request steady while that signal is low. Responses (`rsp_valid` and `mem_rsp_valid`) are single-cycle pulses with no back-pressure.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and neither `rsp_valid` nor `mem_req_valid` is asserted. A line that is invalid never counts as a match, even when its stored key and data are all zero.
- R2: The address splits, from LSB upward, into a byte-offset field of log2(DATA_W/8) bits, an index field of IDX_W bits, and a tag made of the remaining bits. The offset bits have no effect on which line is probed or on whether it matches.
- R3: A read that matches in its home line responds in the cycle after acceptance with `rsp_kind` = 2'b00 (fast hit), `rsp_cycles` = 1, and the line's data on `rsp_rdata`.
- R4: When the home line does not match, the partner line (the index with its MSB inverted) is probed. A read that matches there responds with `rsp_kind` = 2'b01 (pseudo-hit) and `rsp_cycles` = 2.
- R5: After every pseudo-hit the home and partner lines exchange their contents in one extra cycle, during which `req_ready` is 0. A repeat of the same access then becomes a fast hit.
- R6: A read that matches in neither line reports `rsp_kind` = 2'b10 (miss). It issues one lower-level read at the block-aligned address (offset bits zero) and returns `mem_rsp_data`. The fetched block fills the home line, the previous home block moves to the partner line, and the previous partner block is lost.
- R7: Every write issues exactly one lower-level write carrying the block-aligned address and the write data, and the write responds when that write is accepted. A write that matches a line updates that line's data. A write miss leaves the cache unchanged, so a later read of that address misses and returns the written data from below.
- R8: `rsp_cycles` counts the cycles from the one after acceptance up to and including the response cycle. Cycles spent waiting on `mem_req_ready` or `mem_rsp_valid` are included. With no stalls, a read miss reports 4, a fast write 2, and a pseudo-hit or missing write 3.
- R9: `req_ready` is 0 from acceptance until the block returns to idle. While `mem_req_valid` is 1 and `mem_req_ready` is 0, the lower-level request, its address and its direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_kind | output | 2 | 00 fast hit, 01 pseudo-hit, 10 miss |
| rsp_cycles | output | CNT_W | Access latency in cycles |
| rsp_rdata | output | DATA_W | Read data (reads only) |
| mem_req_valid | output | 1 | Lower-level request offered |
| mem_req_ready | input | 1 | Lower level takes the request |
| mem_req_write | output | 1 | Lower-level request is a write |
| mem_addr | output | ADDR_W | Block-aligned lower-level address |
| mem_wdata | output | DATA_W | Lower-level write data |
| mem_rsp_valid | input | 1 | Lower-level read data pulse |
| mem_rsp_data | input | DATA_W | Lower-level read data |

## Verification
The stimulus uses two blocks that share one home index and a third block that lives in the partner index. By reading these in turn, the bench drives the pair through each of its states: cold miss, fast hit, pseudo-hit followed by a swap, a swap back, and a miss that pushes a block out of the pair. Each step tells a correct line exchange apart from a missing one and a correct eviction victim apart from a wrong one. A block whose key and data are all zero is read to separate the valid bit from the stored key. Writes are issued to a home line, to a partner line and to a missing address, which shows where the data lands and that a write miss allocates nothing. Lower-level stalls on both a fetch and a write show that the reported latency grows by exactly the number of stalled cycles.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic [1:0] {
    KIND_FAST   = 2'b00,
    KIND_PSEUDO = 2'b01,
    KIND_MISS   = 2'b10
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_P1, ST_P2, ST_FETCH, ST_WAIT, ST_WR, ST_SWAP
  } st_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_WR_PRI, OP_WR_ALT, OP_FILL, OP_SWAP
  } op_e;
endpackage

// File: rtl/pac_addr_split.sv
module pac_addr_split #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int KEY_W = TAG_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx_home,
  output logic [IDX_W-1:0]  idx_partner,
  output logic [KEY_W-1:0]  key,
  output logic [ADDR_W-1:0] blk_addr
);
  localparam logic [IDX_W-1:0] FLIP = {1'b1, {(IDX_W-1){1'b0}}};

  assign idx_home    = addr[OFF_W +: IDX_W];
  assign idx_partner = idx_home ^ FLIP;
  // The stored key keeps the home index MSB so a line in its partner slot is unambiguous.
  assign key         = {addr[ADDR_W-1 -: TAG_W], addr[OFF_W+IDX_W-1]};
  assign blk_addr    = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/pac_line_store.sv
module pac_line_store
  import pac_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int KEY_W  = 7,
  parameter int DATA_W = 32,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [IDX_W-1:0]  idx_home,
  input  logic [IDX_W-1:0]  idx_partner,
  input  logic [KEY_W-1:0]  new_key,
  input  logic [DATA_W-1:0] new_data,
  output logic              home_valid,
  output logic [KEY_W-1:0]  home_key,
  output logic [DATA_W-1:0] home_data,
  output logic              part_valid,
  output logic [KEY_W-1:0]  part_key,
  output logic [DATA_W-1:0] part_data
);
  logic [LINES-1:0]  vld_q;
  logic [KEY_W-1:0]  key_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  assign home_valid = vld_q[idx_home];
  assign home_key   = key_q[idx_home];
  assign home_data  = dat_q[idx_home];
  assign part_valid = vld_q[idx_partner];
  assign part_key   = key_q[idx_partner];
  assign part_data  = dat_q[idx_partner];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        key_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      case (op)
        OP_WR_PRI: dat_q[idx_home]    <= new_data;
        OP_WR_ALT: dat_q[idx_partner] <= new_data;
        OP_FILL: begin
          vld_q[idx_home]    <= 1'b1;
          key_q[idx_home]    <= new_key;
          dat_q[idx_home]    <= new_data;
          vld_q[idx_partner] <= vld_q[idx_home];
          key_q[idx_partner] <= key_q[idx_home];
          dat_q[idx_partner] <= dat_q[idx_home];
        end
        OP_SWAP: begin
          vld_q[idx_home]    <= vld_q[idx_partner];
          key_q[idx_home]    <= key_q[idx_partner];
          dat_q[idx_home]    <= dat_q[idx_partner];
          vld_q[idx_partner] <= vld_q[idx_home];
          key_q[idx_partner] <= key_q[idx_home];
          dat_q[idx_partner] <= dat_q[idx_home];
        end
        default: ;
      endcase
    end
  end

  // R6
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_FILL |=> home_valid && home_key == $past(new_key) && part_key == $past(home_key));

  // R5
  swap_exchange_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SWAP |=> home_key == $past(part_key) && part_key == $past(home_key)
                      && home_data == $past(part_data));
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
  import pac_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  output logic             req_ready,
  input  logic             hit_home,
  input  logic             hit_part,
  output logic             mem_req_valid,
  output logic             mem_req_write,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  output logic             rsp_valid,
  output kind_e            rsp_kind,
  output logic [CNT_W-1:0] rsp_cycles,
  output op_e              op
);
  st_e              st_q, st_d;
  kind_e            kind_q, kind_d;
  logic             swap_q, swap_d;
  logic             wr_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    st_d          = st_q;
    kind_d        = kind_q;
    swap_d        = swap_q;
    req_ready     = 1'b0;
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    rsp_valid     = 1'b0;
    rsp_kind      = kind_q;
    op            = OP_NONE;
    case (st_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) st_d = ST_P1;
      end
      ST_P1: begin
        swap_d = 1'b0;
        if (hit_home) begin
          kind_d   = KIND_FAST;
          rsp_kind = KIND_FAST;
          if (wr_q) begin
            op   = OP_WR_PRI;
            st_d = ST_WR;
          end else begin
            rsp_valid = 1'b1;
            st_d      = ST_IDLE;
          end
        end else begin
          st_d = ST_P2;
        end
      end
      ST_P2: begin
        if (hit_part) begin
          kind_d   = KIND_PSEUDO;
          rsp_kind = KIND_PSEUDO;
          if (wr_q) begin
            op     = OP_WR_ALT;
            swap_d = 1'b1;
            st_d   = ST_WR;
          end else begin
            rsp_valid = 1'b1;
            st_d      = ST_SWAP;
          end
        end else begin
          kind_d   = KIND_MISS;
          rsp_kind = KIND_MISS;
          st_d     = wr_q ? ST_WR : ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        rsp_kind = KIND_MISS;
        if (mem_rsp_valid) begin
          op        = OP_FILL;
          rsp_valid = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      ST_WR: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        if (mem_req_ready) begin
          rsp_valid = 1'b1;
          st_d      = swap_q ? ST_SWAP : ST_IDLE;
        end
      end
      ST_SWAP: begin
        op   = OP_SWAP;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= KIND_FAST;
      swap_q <= 1'b0;
      wr_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      swap_q <= swap_d;
      if (req_valid && req_ready) begin
        wr_q  <= req_write;
        cnt_q <= CNT_W'(1);
      end else if (st_q != ST_IDLE) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign rsp_cycles = cnt_q;

  // R3
  fast_read_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == KIND_FAST && !wr_q |-> rsp_cycles == CNT_W'(1));

  // R4
  pseudo_read_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == KIND_PSEUDO && !wr_q |-> rsp_cycles == CNT_W'(2));

  // R5
  swap_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == KIND_PSEUDO |=> !req_ready);

  // R9
  busy_while_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R7
  write_rsp_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && wr_q |-> mem_req_valid && mem_req_write && mem_req_ready);
endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache
  import pac_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [CNT_W-1:0]  rsp_cycles,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int KEY_W = ADDR_W - OFF_W - IDX_W + 1;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [IDX_W-1:0]  idx_home, idx_part;
  logic [KEY_W-1:0]  key;
  logic [ADDR_W-1:0] blk_addr;
  logic              home_valid, part_valid;
  logic [KEY_W-1:0]  home_key, part_key;
  logic [DATA_W-1:0] home_data, part_data, new_data;
  logic              hit_home, hit_part;
  op_e               op;
  kind_e             kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_valid && req_ready) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  pac_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
    .addr(addr_q), .idx_home(idx_home), .idx_partner(idx_part),
    .key(key), .blk_addr(blk_addr)
  );

  assign new_data = (op == OP_FILL) ? mem_rsp_data : wdata_q;

  pac_line_store #(.IDX_W(IDX_W), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .op(op),
    .idx_home(idx_home), .idx_partner(idx_part),
    .new_key(key), .new_data(new_data),
    .home_valid(home_valid), .home_key(home_key), .home_data(home_data),
    .part_valid(part_valid), .part_key(part_key), .part_data(part_data)
  );

  assign hit_home = home_valid && (home_key == key);
  assign hit_part = part_valid && (part_key == key);

  pac_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
    .hit_home(hit_home), .hit_part(hit_part),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .rsp_valid(rsp_valid), .rsp_kind(kind), .rsp_cycles(rsp_cycles), .op(op)
  );

  assign rsp_kind  = kind;
  assign mem_addr  = blk_addr;
  assign mem_wdata = wdata_q;

  always_comb begin
    case (kind)
      KIND_FAST:   rsp_rdata = home_data;
      KIND_PSEUDO: rsp_rdata = part_data;
      default:     rsp_rdata = mem_rsp_data;
    endcase
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_req_write));

  // R1
  no_ghost_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !home_valid |-> !hit_home);
endmodule

// File: tb/sim_pseudo_assoc_cache.sv
`timescale 1ns/1ps
module sim_pseudo_assoc_cache;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [1:0] rsp_kind;
  logic [7:0] rsp_cycles;
  logic [DW-1:0] rsp_rdata;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pseudo_assoc_cache u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_cycles(rsp_cycles),
    .rsp_rdata(rsp_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // Lower-level memory model
  logic [DW-1:0] wmem [1024];
  logic [1023:0] wflag;
  int            wr_cnt;
  logic [AW-1:0] last_rd, last_wr_addr;
  logic [DW-1:0] last_wr_data;
  logic [3:0]    stall_left, stall_val = '0;
  logic          stall_go = 1'b0;

  function automatic logic [DW-1:0] base_word(input logic [9:0] b);
    return 32'hA500_0000 ^ {22'd0, b};
  endfunction

  function automatic logic [DW-1:0] rd_word(input logic [9:0] b);
    return wflag[b] ? wmem[b] : base_word(b);
  endfunction

  assign mem_req_ready = (stall_left == 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      wflag <= '0; wr_cnt <= 0; stall_left <= '0; mem_rsp_valid <= 1'b0;
      last_rd <= '0; last_wr_addr <= '0; last_wr_data <= '0;
    end else begin
      mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_write;
      if (mem_req_valid && mem_req_ready && !mem_req_write) begin
        mem_rsp_data <= rd_word(mem_addr[11:2]);
        last_rd      <= mem_addr;
      end
      if (mem_req_valid && mem_req_ready && mem_req_write) begin
        wmem[mem_addr[11:2]]  <= mem_wdata;
        wflag[mem_addr[11:2]] <= 1'b1;
        wr_cnt       <= wr_cnt + 1;
        last_wr_addr <= mem_addr;
        last_wr_data <= mem_wdata;
      end
      if (stall_go) stall_left <= stall_val;
      else if (mem_req_valid && stall_left != 0) stall_left <= stall_left - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard
  typedef struct {
    logic [1:0]  kind;
    int          cycles;
    bit          use_data;
    logic [DW-1:0] data;
    string       req;
  } exp_t;
  exp_t sb[$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_kind == e.kind, e.req, "kind", rsp_kind, e.kind);
        chk(int'(rsp_cycles) == e.cycles, e.req, "cycles", rsp_cycles, e.cycles);
        if (e.use_data) chk(rsp_rdata == e.data, e.req, "data", rsp_rdata, e.data);
      end
    end
  end

  function automatic logic [AW-1:0] mk(input int tag, input int idx, input int off);
    return {tag[5:0], idx[3:0], off[1:0]};
  endfunction

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [1:0] ek, input int ec, input bit ud,
                        input logic [DW-1:0] ed, input string req);
    exp_t e;
    e.kind = ek; e.cycles = ec; e.use_data = ud; e.data = ed; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    do @(posedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
  endtask

  task automatic set_stall(input int n);
    @(negedge clk);
    stall_val = n[3:0]; stall_go = 1'b1;
    @(negedge clk);
    stall_go = 1'b0;
  endtask

  function automatic logic [DW-1:0] bw(input logic [AW-1:0] a);
    return base_word(a[11:2]);
  endfunction

  localparam logic [1:0] KF = 2'b00, KP = 2'b01, KM = 2'b10;

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] A, B, C, D, E, F;
    int wc;
    A = mk(1, 3, 0); B = mk(2, 3, 0); C = mk(5, 11, 0);
    D = mk(0, 5, 0); E = mk(7, 6, 0); F = mk(9, 2, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);

    // R6 cold miss, block-aligned fetch
    access(0, A | 12'h1, 0, KM, 4, 1, bw(A), "R6");
    @(negedge clk);
    chk(last_rd == A, "R6", "fetch address", last_rd, A);
    // R3 / R2: fast hit with a different offset
    access(0, A | 12'h2, 0, KF, 1, 1, bw(A), "R3");
    access(0, A | 12'h3, 0, KF, 1, 1, bw(A), "R2");
    // B shares the home index: A moves to the partner line
    access(0, B, 0, KM, 4, 1, bw(B), "R6");
    // R4 pseudo-hit on A
    access(0, A, 0, KP, 2, 1, bw(A), "R4");
    @(negedge clk);
    chk(req_ready == 1'b0, "R5", "req_ready during swap", req_ready, 0);
    // R5 after swap A is fast, B now pseudo
    access(0, A, 0, KF, 1, 1, bw(A), "R5");
    access(0, B, 0, KP, 2, 1, bw(B), "R5");
    // R6 C homes at the partner index; evicts partner content (B)
    access(0, C, 0, KM, 4, 1, bw(C), "R6");
    access(0, B, 0, KM, 4, 1, bw(B), "R6");
    // R1 invalid line with all-zero key/data must miss
    access(0, D, 0, KM, 4, 1, bw(D), "R1");

    // R7 write hit in home line
    wc = wr_cnt;
    access(1, B, 32'h1111_0001, KF, 2, 0, 0, "R7");
    @(negedge clk);
    chk(wr_cnt == wc + 1, "R7", "write count", wr_cnt, wc + 1);
    chk(last_wr_addr == B, "R7", "write addr", last_wr_addr, B);
    chk(last_wr_data == 32'h1111_0001, "R7", "write data", last_wr_data, 32'h1111_0001);
    access(0, B, 0, KF, 1, 1, 32'h1111_0001, "R7");
    // R7 write pseudo-hit then swap
    access(1, A, 32'h2222_0002, KP, 3, 0, 0, "R8");
    access(0, A, 0, KF, 1, 1, 32'h2222_0002, "R7");
    // R7 write miss: no allocate
    wc = wr_cnt;
    access(1, E, 32'h3333_0003, KM, 3, 0, 0, "R7");
    @(negedge clk);
    chk(wr_cnt == wc + 1, "R7", "write-miss count", wr_cnt, wc + 1);
    access(0, E, 0, KM, 4, 1, 32'h3333_0003, "R7");

    // R8 stalls counted
    set_stall(3);
    access(0, F, 0, KM, 7, 1, bw(F), "R8");
    set_stall(2);
    access(1, A, 32'h4444_0004, KF, 4, 0, 0, "R8");
    access(0, A, 0, KF, 1, 1, 32'h4444_0004, "R9");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R9", "responses outstanding", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule